// File: doc/BRIEF.md
# Quarter-Rate Quadrature Downconvert-Decimate Filter

This block turns a stream of real samples into a complex stream at half the input rate. It moves the spectrum by a quarter of the sample rate, low-pass filters the real and imaginary parts with the same halfband response, and keeps every second result. A sideband-select pin sets the direction of the shift. A value of 1 shifts down, which centres the upper sideband on DC. A value of 0 shifts up, which centres the lower sideband on DC.

There is no mixer multiplier. The quarter-rate local oscillator only ever takes the values +1, 0 and -1. Samples at even positions therefore reach the real filter with a sign flip on every second one. Samples at odd positions reach the imaginary filter the same way. The zero products are never formed. Each branch holds only its own polyphase half of the taps. Both outputs are doubled to make up for the half-power loss of mixing, then saturated to the output width.

Input and output are valid/ready streams. An input sample moves when `in_valid` and `in_ready` are both high at a clock edge. A result is held stable on the output until `out_ready` takes it. While a result waits, no new sample is accepted. A `start` pulse rewinds the sample index and clears the filter history.

Top module: `qtr_ddc_dec`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, the sample index is 0 and both filter histories hold zero.
- R2: `in_ready` equals `!start && (!out_valid || out_ready)`. A sample is accepted when `in_valid && in_ready`. While `out_valid && !out_ready`, the output data and `out_valid` stay unchanged.
- R3: Accepting a sample at an even index (index mod 4 is 0 or 2) raises `out_valid` with a new result on the next cycle. Accepting a sample at an odd index leaves `out_valid` low on the next cycle. Each even-index sample yields exactly one output.
- R4: `out_i` is built only from even-index samples and the even-numbered coefficients. A sample at index mod 4 = 0 enters with its own sign and one at index mod 4 = 2 enters negated, whatever `sb_sel` is. For even n, the value is the full 67-tap filter of the mixed real stream, evaluated at n.
- R5: `out_q` is built only from odd-index samples and the odd-numbered coefficients. With `sb_sel`=1 (downward shift), a sample at index mod 4 = 1 enters negated and one at index mod 4 = 3 enters with its own sign. With `sb_sel`=0, both signs are reversed. `sb_sel` is taken with each accepted sample.
- R6: Each output component is floor((2 * sum) / 2^FRAC), where FRAC is 17 by default. It is clamped to the signed OW-bit range, so it never exceeds +32767 or falls below -32768 at OW=16.
- R7: While `start` is high, no sample is accepted. On the following cycle `out_valid` is 0, the index is 0 and both histories are zero, even if a result was waiting.
- R8: The index advances by one only on an accepted sample and wraps modulo 4. Stalled or idle cycles leave it unchanged. An input of -32768 negated by the mixer is carried as +32768 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Rewinds the sample index, clears history and drops any waiting result |
| sb_sel | input | 1 | 1: downward quarter-rate shift (upper sideband to DC); 0: upward shift |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | DW (16) | Signed real input sample |
| out_valid | output | 1 | Complex result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_i | output | OW (16) | Signed real (in-phase) output |
| out_q | output | OW (16) | Signed imaginary (quadrature) output |

## Verification
The hardest case to reach is a `start` pulse that arrives while a result is held back by a low `out_ready`, because the pending result and the history must both disappear in the same cycle. The stimulus gets there by feeding one even-index sample with `out_ready` low, holding for a cycle, and then pulsing `start`. Saturation is also hard to hit through a halfband filter. The bench drives a full-scale sequence whose sign flips match the mixer, so the real branch sees a constant full-scale value and overshoots the output range. It also drives a run of -32768 samples, so the mixer negation lands exactly one step past the positive limit on the imaginary branch.

// File: rtl/qddc_pkg.sv
`timescale 1ns/1ps
package qddc_pkg;

  localparam int MAX_TAPS = 127;
  localparam int CWORD    = 32;

  // coefficient k lives in bits [k*CWORD +: CWORD], signed, low CW bits used
  typedef logic [MAX_TAPS*CWORD-1:0] coef_vec_t;

  // Default halfband set: centre tap = 0.5, odd-offset taps follow a
  // triangle-windowed sinc, even-offset taps are zero.
  function automatic coef_vec_t hb_default(input int ntaps, input int cw);
    coef_vec_t v;
    int        ctr;
    int        half;
    longint    w;
    v    = '0;
    ctr  = (ntaps - 1) / 2;
    half = (ctr + 1) / 2;
    for (int k = 0; k < ntaps; k++) begin
      int d;
      int ad;
      d  = k - ctr;
      ad = (d < 0) ? -d : d;
      w  = 0;
      if (d == 0) begin
        w = longint'(1) <<< (cw - 2);
      end else if ((ad % 2) == 1) begin
        int m;
        m = (ad - 1) / 2;
        w = ((longint'(1) <<< (cw - 1)) * 10 * longint'(half - m)) /
            (longint'(32) * half * ad);
        if ((m % 2) == 1) w = -w;
      end
      v[k*CWORD +: CWORD] = w[CWORD-1:0];
    end
    return v;
  endfunction

endpackage

// File: rtl/qddc_phase.sv
`timescale 1ns/1ps
module qddc_phase (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       adv,
  output logic [1:0] idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= 2'd0;
    else if (start) idx <= 2'd0;
    else if (adv)   idx <= idx + 2'd1;
  end

  // R8: one step per accepted sample, wrap modulo 4
  a_r8_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !start) |=> (idx == $past(idx) + 2'd1));

  // R8: no movement without an accepted sample
  a_r8_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !start) |=> $stable(idx));

  // R7: start rewinds the index
  a_r7_start_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (idx == 2'd0));

endmodule

// File: rtl/qddc_branch.sv
`timescale 1ns/1ps
module qddc_branch #(
  parameter int                  SW    = 17,
  parameter int                  CW    = 18,
  parameter int                  AW    = 42,
  parameter int                  NTAPS = 67,
  parameter int                  PHASE = 0,
  parameter bit                  LIVE  = 1'b1,
  parameter qddc_pkg::coef_vec_t COEFS = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 push,
  input  logic signed [SW-1:0] din,
  output logic signed [AW-1:0] acc
);

  localparam int NSUB  = (NTAPS - PHASE + 1) / 2;
  localparam int DEPTH = LIVE ? NSUB - 1 : NSUB;
  localparam int PW    = SW + CW;

  logic signed [SW-1:0] line [DEPTH];
  logic signed [SW-1:0] tap  [NSUB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) line[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) line[i] <= '0;
    end else if (push) begin
      line[0] <= din;
      for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
    end
  end

  generate
    if (LIVE) begin : g_live
      assign tap[0] = din;
      for (genvar j = 1; j < NSUB; j++) begin : g_tap
        assign tap[j] = line[j-1];
      end
    end else begin : g_stored
      for (genvar j = 0; j < NSUB; j++) begin : g_tap
        assign tap[j] = line[j];
      end
    end
  endgenerate

  always_comb begin
    logic signed [CW-1:0] cj;
    logic signed [PW-1:0] prod;
    acc = '0;
    for (int j = 0; j < NSUB; j++) begin
      cj   = $signed(COEFS[(2*j+PHASE)*qddc_pkg::CWORD +: CW]);
      prod = PW'(tap[j]) * PW'(cj);
      acc  = acc + AW'(prod);
    end
  end

  // R7: a clear leaves the history empty
  a_r7_history_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (line[0] == '0 && line[DEPTH-1] == '0));

  // R8: the history moves only on a push
  a_r8_history_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !clr) |=> $stable(line[0]));

endmodule

// File: rtl/qddc_scale_sat.sv
`timescale 1ns/1ps
module qddc_scale_sat #(
  parameter int AW   = 42,
  parameter int OW   = 16,
  parameter int FRAC = 17
) (
  input  logic signed [AW-1:0] acc,
  output logic signed [OW-1:0] y
);

  logic signed [AW:0] dbl;
  logic signed [AW:0] shf;

  always_comb begin
    dbl = $signed({acc, 1'b0});
    shf = dbl >>> FRAC;
    if (&shf[AW:OW-1] || ~|shf[AW:OW-1])
      y = shf[OW-1:0];
    else if (shf[AW])
      y = {1'b1, {(OW-1){1'b0}}};
    else
      y = {1'b0, {(OW-1){1'b1}}};
  end

endmodule

// File: rtl/qtr_ddc_dec.sv
`timescale 1ns/1ps
module qtr_ddc_dec #(
  parameter int                  DW    = 16,
  parameter int                  CW    = 18,
  parameter int                  NTAPS = 67,
  parameter int                  OW    = 16,
  parameter int                  FRAC  = CW - 1,
  parameter qddc_pkg::coef_vec_t COEFS = qddc_pkg::hb_default(NTAPS, CW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sb_sel,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_i,
  output logic [OW-1:0] out_q
);

  localparam int SW = DW + 1;
  localparam int AW = SW + CW + $clog2(NTAPS);

  logic                 accept;
  logic [1:0]           idx;
  logic signed [SW-1:0] xe;
  logic signed [SW-1:0] xn;
  logic                 leg_push [2];
  logic signed [SW-1:0] leg_in   [2];
  logic signed [AW-1:0] leg_acc  [2];
  logic signed [OW-1:0] leg_out  [2];

  assign in_ready = !start && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  qddc_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .adv   (accept),
    .idx   (idx)
  );

  // quarter-rate mix as sign selection on a sign-extended sample
  assign xe = $signed({in_data[DW-1], in_data});
  assign xn = -xe;

  assign leg_push[0] = accept && !idx[0];
  assign leg_push[1] = accept &&  idx[0];
  assign leg_in[0]   = idx[1] ? xn : xe;
  assign leg_in[1]   = (idx[1] == sb_sel) ? xe : xn;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_leg
      qddc_branch #(
        .SW    (SW),
        .CW    (CW),
        .AW    (AW),
        .NTAPS (NTAPS),
        .PHASE (g),
        .LIVE  (g == 0),
        .COEFS (COEFS)
      ) u_branch (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .push  (leg_push[g]),
        .din   (leg_in[g]),
        .acc   (leg_acc[g])
      );

      qddc_scale_sat #(
        .AW   (AW),
        .OW   (OW),
        .FRAC (FRAC)
      ) u_scale (
        .acc (leg_acc[g]),
        .y   (leg_out[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (start) begin
      out_valid <= 1'b0;
    end else if (leg_push[0]) begin
      out_valid <= 1'b1;
      out_i     <= leg_out[0];
      out_q     <= leg_out[1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2: a result held back by the consumer does not change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=>
      (out_valid && $stable(out_i) && $stable(out_q)));

  // R2: nothing enters while a result waits
  a_r2_no_accept_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !accept);

  // R3: an even-index sample produces a result next cycle
  a_r3_even_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !idx[0]) |=> out_valid);

  // R3: an odd-index sample produces nothing
  a_r3_odd_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && idx[0]) |=> !out_valid);

  // R7: start drops any waiting result
  a_r7_start_flush: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_valid);

endmodule

// File: tb/qtr_ddc_dec_tb.sv
`timescale 1ns/1ps
module qtr_ddc_dec_tb;

  localparam int DW   = 16;
  localparam int CW   = 18;
  localparam int NT   = 67;
  localparam int OW   = 16;
  localparam int FRAC = 17;

  function automatic int coef_at(input int k);
    int d;
    int ad;
    int m;
    int w;
    d  = k - 33;
    ad = (d < 0) ? -d : d;
    if (d == 0) return 65536;
    if ((ad % 2) == 0) return 0;
    m = (ad - 1) / 2;
    w = (60000 * (17 - m)) / (17 * ad);
    return ((m % 2) == 1) ? -w : w;
  endfunction

  function automatic qddc_pkg::coef_vec_t build_coefs();
    qddc_pkg::coef_vec_t v;
    v = '0;
    for (int k = 0; k < NT; k++) v[k*32 +: 32] = coef_at(k);
    return v;
  endfunction

  localparam qddc_pkg::coef_vec_t TB_COEFS = build_coefs();

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          sb_sel = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [OW-1:0] out_i;
  logic [OW-1:0] out_q;

  always #2.5 clk = ~clk;

  qtr_ddc_dec #(
    .DW(DW), .CW(CW), .NTAPS(NT), .OW(OW), .FRAC(FRAC), .COEFS(TB_COEFS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sb_sel(sb_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  int     nchecks = 0;
  int     nfails  = 0;
  int     cyc     = 0;
  bit     done    = 0;
  int     hb [NT];
  longint rq[$];
  longint qq[$];
  longint exp_i[$];
  longint exp_q[$];
  int     nidx = 0;
  bit     pend = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    nchecks++;
    if (!ok) begin
      nfails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic longint sat(input longint s);
    longint y;
    y = (2 * s) >>> FRAC;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y;
  endfunction

  function automatic void model_clear();
    rq.delete(); qq.delete(); exp_i.delete(); exp_q.delete();
    nidx = 0;
  endfunction

  // full mix, full 67-tap filter on both streams, keep even-index outputs
  function automatic void model_accept(input int x, input bit sb);
    int     ph;
    longint r;
    longint q;
    ph = nidx % 4;
    r = 0; q = 0;
    case (ph)
      0: r = x;
      1: q = sb ? -x : x;
      2: r = -x;
      default: q = sb ? x : -x;
    endcase
    rq.push_front(r); qq.push_front(q);
    if (rq.size() > NT) begin void'(rq.pop_back()); void'(qq.pop_back()); end
    if ((ph % 2) == 0) begin
      longint si;
      longint sq;
      si = 0; sq = 0;
      for (int k = 0; k < rq.size(); k++) begin
        si += longint'(hb[k]) * rq[k];
        sq += longint'(hb[k]) * qq[k];
      end
      exp_i.push_back(sat(si));
      exp_q.push_back(sat(sq));
    end
    nidx++;
  endfunction

  task automatic step(input bit v, input int x, input bit sb, input bit st,
                      input bit rdy, input string tag);
    bit exp_ready;
    bit xfer;
    bit acc;
    @(negedge clk);
    in_valid = v; in_data = x[DW-1:0]; sb_sel = sb; start = st; out_ready = rdy;
    #1;
    exp_ready = !st && (!pend || rdy);
    check(in_ready == exp_ready, st ? "R7 ready during start" : "R2 ready",
          longint'(in_ready), longint'(exp_ready));
    check(out_valid == pend, "R3 valid", longint'(out_valid), longint'(pend));
    xfer = pend && rdy;
    if (out_valid && rdy) begin
      if (exp_i.size() == 0) begin
        check(0, "R3 unexpected output", 1, 0);
      end else begin
        longint ei;
        longint eq;
        ei = exp_i.pop_front(); eq = exp_q.pop_front();
        check($signed(out_i) == ei,
              (ei == 32767 || ei == -32768) ? {"R6 real, seg ", tag} : {"R4 real, seg ", tag},
              longint'($signed(out_i)), ei);
        check($signed(out_q) == eq,
              (eq == 32767 || eq == -32768) ? {"R6 imag, seg ", tag} : {"R5 imag, seg ", tag},
              longint'($signed(out_q)), eq);
      end
    end
    acc = v && exp_ready;
    if (st) begin
      model_clear();
      pend = 0;
    end else begin
      if (xfer) pend = 0;
      if (acc) begin
        if ((nidx % 2) == 0) pend = 1;
        model_accept(x, sb);
      end
    end
  endtask

  function automatic int rnd_sample();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !done) begin
      nfails++;
      $display("FAIL R3 watchdog: actual %0d cycles expected fewer than 100000", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(7));
    for (int k = 0; k < NT; k++) hb[k] = coef_at(k);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(in_ready == 1'b1, "R1 ready after reset", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R1 valid after reset", longint'(out_valid), 0);

    // R4: real impulse at index 0, start offered with a valid sample
    step(1, 500, 1, 1, 1, "R7");
    step(1, 1000, 1, 0, 1, "R4");
    for (int i = 0; i < 80; i++) step(1, 0, 1, 0, 1, "R4");

    // R5: imaginary impulse at index 1, both sideband settings
    step(0, 0, 1, 1, 1, "R7");
    step(1, 0, 1, 0, 1, "R5");
    step(1, 1000, 1, 0, 1, "R5");
    for (int i = 0; i < 72; i++) step(1, 0, 1, 0, 1, "R5");
    step(0, 0, 0, 1, 1, "R7");
    step(1, 0, 0, 0, 1, "R5");
    step(1, 1000, 0, 0, 1, "R5");
    for (int i = 0; i < 72; i++) step(1, 0, 0, 0, 1, "R5");

    // R5: random data, gaps in valid, downward then upward shift
    for (int i = 0; i < 200; i++)
      step($urandom_range(0, 3) != 0, rnd_sample(), 1, 0, 1, "R5");
    for (int i = 0; i < 200; i++)
      step($urandom_range(0, 3) != 0, rnd_sample(), 0, 0, 1, "R5");

    // R2 R8: random back-pressure stalls the index
    for (int i = 0; i < 300; i++)
      step($urandom_range(0, 3) != 0, rnd_sample(), 1, 0,
           $urandom_range(0, 2) != 0, "R2");

    // R6: sign pattern that the mixer turns into a constant full-scale value
    step(0, 0, 1, 1, 1, "R7");
    for (int i = 0; i < 120; i++)
      step(1, ((i % 4) == 0) ? 32767 : (((i % 4) == 2) ? -32767 : 0), 1, 0, 1, "R6");
    step(0, 0, 1, 1, 1, "R7");
    for (int i = 0; i < 120; i++)
      step(1, ((i % 4) == 0) ? -32768 : (((i % 4) == 2) ? 32767 : 0), 1, 0, 1, "R6");

    // R8: minimum input negated by the mixer
    step(0, 0, 1, 1, 1, "R7");
    for (int i = 0; i < 90; i++) step(1, -32768, 1, 0, 1, "R8");

    // R7: start while a result waits under back-pressure
    step(0, 0, 1, 1, 1, "R7");
    step(1, 1234, 1, 0, 0, "R7");
    step(1, 999, 1, 0, 0, "R2");
    step(0, 0, 1, 1, 0, "R7");
    step(0, 0, 1, 0, 1, "R7");
    check(out_valid == 1'b0, "R7 pending dropped", longint'(out_valid), 0);
    step(1, 2000, 1, 0, 1, "R7");
    for (int i = 0; i < 40; i++) step(1, rnd_sample(), 1, 0, 1, "R7");

    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 1, "R3");
    check(exp_i.size() == 0, "R3 outputs left over", longint'(exp_i.size()), 0);

    finish_run();
  end

endmodule